// File: doc/BRIEF.md
# Four-Mode Window Result Comparator

This block sits after a converter and decides, one result at a time, whether a finished conversion is kept. Each unsigned result is tested against two signed thresholds, called the lower-index threshold (`thr_a`) and the second threshold (`thr_b`), under one of four compare modes. A result that passes is latched into the output register and a one-cycle completion pulse is raised. A result that fails leaves no trace: the register keeps its old value and no pulse is raised.

When the compare function is switched off, every result passes. The two two-threshold modes change meaning with the order of the thresholds. When `thr_a` is at most `thr_b`, one mode keeps results outside the window and the other keeps results inside it. When `thr_a` is greater than `thr_b`, the two roles swap.

Top module: `result_window_filter`

## Requirements
- R1: While `rst_n` is low, `out_data` is 0 and `done` is 0. The reset is asynchronous.
- R2: With `cmp_en` low, every valid result is accepted whatever the mode and thresholds are.
- R3: With `cmp_en` high and `cmp_mode` = 0, a result x is accepted only when x < `thr_a`. Equality rejects.
- R4: With `cmp_mode` = 1, x is accepted only when x > `thr_a`. Equality rejects.
- R5: With `cmp_mode` = 2 and `thr_a` ≤ `thr_b`, x is accepted when x < `thr_a` or x > `thr_b`. Results on either threshold are rejected.
- R6: With `cmp_mode` = 2 and `thr_a` > `thr_b`, x is accepted only when `thr_b` < x < `thr_a`, with both bounds strict.
- R7: With `cmp_mode` = 3 and `thr_a` ≤ `thr_b`, x is accepted when `thr_a` ≤ x ≤ `thr_b`, with both bounds inclusive.
- R8: With `cmp_mode` = 3 and `thr_a` > `thr_b`, x is accepted when x ≥ `thr_a` or x ≤ `thr_b`.
- R9: A rejected result does not change `out_data` and does not raise `done`.
- R10: `done` is high for the one cycle after each clock edge at which an accepted result was presented with `res_valid` high, and is low otherwise. `out_data` changes only in that same cycle.
- R11: The thresholds are two's-complement `THR_W`-bit values. The result is treated as a non-negative number, zero-extended, so a full-scale result compares above any negative threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Compare enable; low accepts every result |
| cmp_mode | input | 2 | Compare mode select, 0 to 3 |
| thr_a | input | THR_W (16) | First signed threshold |
| thr_b | input | THR_W (16) | Second signed threshold |
| res_valid | input | 1 | Conversion result present this cycle |
| res_data | input | RES_W (12) | Unsigned conversion result |
| out_data | output | RES_W (12) | Last accepted result |
| done | output | 1 | One-cycle pulse: a result was accepted |

## Verification
Both `done` and `out_data` are due exactly one clock edge after the edge that samples `res_valid`. The bench therefore drives each result at a falling edge, lets one rising edge pass, and samples at the following falling edge. One more cycle later it checks that the pulse has dropped and the data has held. Reset is asynchronous, so it is checked a fraction of a cycle after `rst_n` falls, with no clock edge in between.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
   typedef enum logic [1:0] {
      MODE_BELOW  = 2'd0,
      MODE_ABOVE  = 2'd1,
      MODE_SPLIT  = 2'd2,
      MODE_BAND   = 2'd3
   } cmp_mode_e;
endpackage

// File: rtl/rwf_extend.sv
module rwf_extend #(
   parameter int RES_W = 12,
   parameter int THR_W = 16,
   parameter int CMP_W = 17
) (
   input  logic [RES_W-1:0]        res_data,
   input  logic [THR_W-1:0]        thr_a,
   input  logic [THR_W-1:0]        thr_b,
   output logic signed [CMP_W-1:0] x_ext,
   output logic signed [CMP_W-1:0] a_ext,
   output logic signed [CMP_W-1:0] b_ext
);
   localparam int XPAD = CMP_W - RES_W;
   localparam int TPAD = CMP_W - THR_W;

   // result is unsigned: zero fill; thresholds are two's complement: sign fill
   assign x_ext = signed'({{XPAD{1'b0}}, res_data});
   assign a_ext = signed'({{TPAD{thr_a[THR_W-1]}}, thr_a});
   assign b_ext = signed'({{TPAD{thr_b[THR_W-1]}}, thr_b});
endmodule

// File: rtl/rwf_decide.sv
module rwf_decide
   import rwf_pkg::*;
#(
   parameter int CMP_W   = 17,
   parameter bit HAS_CMP = 1'b1
) (
   input  logic                    cmp_en,
   input  logic [1:0]              cmp_mode,
   input  logic signed [CMP_W-1:0] x_ext,
   input  logic signed [CMP_W-1:0] a_ext,
   input  logic signed [CMP_W-1:0] b_ext,
   output logic                    accept
);
   generate
      if (HAS_CMP) begin : g_cmp
         logic lt_a, gt_a, gt_b, ordered;
         logic pass;
         assign lt_a    = x_ext < a_ext;
         assign gt_a    = x_ext > a_ext;
         assign gt_b    = x_ext > b_ext;
         assign ordered = a_ext <= b_ext;

         always_comb begin
            unique case (cmp_mode_e'(cmp_mode))
               MODE_BELOW: pass = lt_a;
               MODE_ABOVE: pass = gt_a;
               MODE_SPLIT: pass = ordered ? (lt_a | gt_b) : (lt_a & gt_b);
               MODE_BAND:  pass = ordered ? (~lt_a & ~gt_b) : (~lt_a | ~gt_b);
               default:    pass = 1'b0;
            endcase
         end
         assign accept = ~cmp_en | pass;
      end else begin : g_bypass
         logic unused_in;
         assign unused_in = ^{cmp_en, cmp_mode, x_ext, a_ext, b_ext};
         assign accept    = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/rwf_capture.sv
module rwf_capture #(
   parameter int RES_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_valid,
   input  logic             accept,
   input  logic [RES_W-1:0] res_data,
   output logic [RES_W-1:0] out_data,
   output logic             done
);
   logic take;
   assign take = res_valid & accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data <= '0;
         done     <= 1'b0;
      end else begin
         done <= take;
         if (take) out_data <= res_data;
      end
   end
endmodule

// File: rtl/result_window_filter.sv
module result_window_filter #(
   parameter int RES_W   = 12,
   parameter int THR_W   = 16,
   parameter bit HAS_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_en,
   input  logic [1:0]       cmp_mode,
   input  logic [THR_W-1:0] thr_a,
   input  logic [THR_W-1:0] thr_b,
   input  logic             res_valid,
   input  logic [RES_W-1:0] res_data,
   output logic [RES_W-1:0] out_data,
   output logic             done
);
   localparam int CMP_W = ((RES_W > THR_W) ? RES_W : THR_W) + 1;

   generate
      if (RES_W < 1) begin : g_bad_res
         $error("result_window_filter: RES_W must be at least 1");
      end
      if (THR_W < 2) begin : g_bad_thr
         $error("result_window_filter: THR_W must be at least 2");
      end
   endgenerate

   logic signed [CMP_W-1:0] x_ext, a_ext, b_ext;
   logic                    accept;

   rwf_extend #(.RES_W(RES_W), .THR_W(THR_W), .CMP_W(CMP_W)) u_ext (
      .res_data (res_data),
      .thr_a    (thr_a),
      .thr_b    (thr_b),
      .x_ext    (x_ext),
      .a_ext    (a_ext),
      .b_ext    (b_ext)
   );

   rwf_decide #(.CMP_W(CMP_W), .HAS_CMP(HAS_CMP)) u_dec (
      .cmp_en   (cmp_en),
      .cmp_mode (cmp_mode),
      .x_ext    (x_ext),
      .a_ext    (a_ext),
      .b_ext    (b_ext),
      .accept   (accept)
   );

   rwf_capture #(.RES_W(RES_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .accept    (accept),
      .res_data  (res_data),
      .out_data  (out_data),
      .done      (done)
   );
endmodule

// File: rtl/rwf_checker.sv
module rwf_checker #(
   parameter int RES_W   = 12,
   parameter int THR_W   = 16,
   parameter bit HAS_CMP = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmp_en,
   input logic [1:0]       cmp_mode,
   input logic [THR_W-1:0] thr_a,
   input logic [THR_W-1:0] thr_b,
   input logic             res_valid,
   input logic [RES_W-1:0] res_data,
   input logic [RES_W-1:0] out_data,
   input logic             done
);
   localparam int W = ((RES_W > THR_W) ? RES_W : THR_W) + 1;

   logic signed [W-1:0] xs, as_v;
   assign xs   = signed'({{(W-RES_W){1'b0}}, res_data});
   assign as_v = signed'({{(W-THR_W){thr_a[THR_W-1]}}, thr_a});

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!done && out_data == '0));

   // R10
   done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(res_valid));

   // R9
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(out_data));

   // R2
   bypass_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !cmp_en) |=> (done && out_data == $past(res_data)));

   generate
      if (HAS_CMP) begin : g_mode_chk
         // R3
         below_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && cmp_en && cmp_mode == 2'd0 && xs >= as_v) |=> !done);
         // R4
         above_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && cmp_en && cmp_mode == 2'd1 && xs <= as_v) |=> !done);
      end
   endgenerate
endmodule

bind result_window_filter rwf_checker #(
   .RES_W(RES_W), .THR_W(THR_W), .HAS_CMP(HAS_CMP)
) u_rwf_chk (
   .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .cmp_mode(cmp_mode),
   .thr_a(thr_a), .thr_b(thr_b), .res_valid(res_valid), .res_data(res_data),
   .out_data(out_data), .done(done)
);

// File: tb/tb_result_window_filter.sv
module tb_result_window_filter;
   localparam int RES_W = 12;
   localparam int THR_W = 16;

   typedef struct packed {
      logic        en;
      logic [1:0]  mode;
      logic [15:0] a;
      logic [15:0] b;
      logic [11:0] x;
      logic        acc;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VT [NV] = '{
      '{1'b0, 2'd0, 16'h0000, 16'h0000, 12'd100,  1'b1, 4'd2},  // R2
      '{1'b0, 2'd1, 16'h7FFF, 16'h0000, 12'd5,    1'b1, 4'd2},  // R2
      '{1'b1, 2'd0, 16'd100,  16'd0,    12'd99,   1'b1, 4'd3},  // R3
      '{1'b1, 2'd0, 16'd100,  16'd0,    12'd100,  1'b0, 4'd3},  // R3
      '{1'b1, 2'd1, 16'd100,  16'd0,    12'd101,  1'b1, 4'd4},  // R4
      '{1'b1, 2'd1, 16'd100,  16'd0,    12'd100,  1'b0, 4'd4},  // R4
      '{1'b1, 2'd2, 16'd100,  16'd200,  12'd50,   1'b1, 4'd5},  // R5
      '{1'b1, 2'd2, 16'd100,  16'd200,  12'd100,  1'b0, 4'd5},  // R5
      '{1'b1, 2'd2, 16'd100,  16'd200,  12'd200,  1'b0, 4'd5},  // R5
      '{1'b1, 2'd2, 16'd100,  16'd200,  12'd201,  1'b1, 4'd5},  // R5
      '{1'b1, 2'd2, 16'd100,  16'd200,  12'd150,  1'b0, 4'd5},  // R5
      '{1'b1, 2'd2, 16'd200,  16'd100,  12'd150,  1'b1, 4'd6},  // R6
      '{1'b1, 2'd2, 16'd200,  16'd100,  12'd200,  1'b0, 4'd6},  // R6
      '{1'b1, 2'd2, 16'd200,  16'd100,  12'd100,  1'b0, 4'd6},  // R6
      '{1'b1, 2'd2, 16'd200,  16'd100,  12'd50,   1'b0, 4'd6},  // R6
      '{1'b1, 2'd3, 16'd100,  16'd200,  12'd100,  1'b1, 4'd7},  // R7
      '{1'b1, 2'd3, 16'd100,  16'd200,  12'd200,  1'b1, 4'd7},  // R7
      '{1'b1, 2'd3, 16'd100,  16'd200,  12'd99,   1'b0, 4'd7},  // R7
      '{1'b1, 2'd3, 16'd100,  16'd200,  12'd201,  1'b0, 4'd7},  // R7
      '{1'b1, 2'd3, 16'd300,  16'd300,  12'd300,  1'b1, 4'd7},  // R7 equal thresholds
      '{1'b1, 2'd3, 16'd200,  16'd100,  12'd200,  1'b1, 4'd8},  // R8
      '{1'b1, 2'd3, 16'd200,  16'd100,  12'd100,  1'b1, 4'd8},  // R8
      '{1'b1, 2'd3, 16'd200,  16'd100,  12'd150,  1'b0, 4'd8},  // R8
      '{1'b1, 2'd3, 16'd200,  16'd100,  12'd300,  1'b1, 4'd8},  // R8
      '{1'b1, 2'd2, 16'd300,  16'd300,  12'd300,  1'b0, 4'd5},  // R5 equal thresholds
      '{1'b1, 2'd1, 16'hFFFF, 16'h0000, 12'hFFF,  1'b1, 4'd11}, // R11 full scale above -1
      '{1'b1, 2'd0, 16'hFFFF, 16'h0000, 12'h000,  1'b0, 4'd11}, // R11 zero not below -1
      '{1'b1, 2'd0, 16'h8000, 16'h0000, 12'h000,  1'b0, 4'd11}, // R11 most negative
      '{1'b1, 2'd1, 16'h0FFF, 16'h0000, 12'hFFF,  1'b0, 4'd11}  // R11 equal at full scale
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmp_en = 1'b0;
   logic [1:0]       cmp_mode = 2'd0;
   logic [THR_W-1:0] thr_a = '0;
   logic [THR_W-1:0] thr_b = '0;
   logic             res_valid = 1'b0;
   logic [RES_W-1:0] res_data = '0;
   logic [RES_W-1:0] out_data;
   logic             done;

   int checks = 0;
   int errors = 0;
   logic [RES_W-1:0] model_q = '0;

   always #5 clk = ~clk;

   result_window_filter #(.RES_W(RES_W), .THR_W(THR_W)) dut (
      .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .cmp_mode(cmp_mode),
      .thr_a(thr_a), .thr_b(thr_b), .res_valid(res_valid), .res_data(res_data),
      .out_data(out_data), .done(done)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, one rising edge samples, check at next falling edge
   task automatic apply(input logic en, input logic [1:0] mode,
                        input logic [15:0] a, input logic [15:0] b,
                        input logic [11:0] x);
      cmp_en = en; cmp_mode = mode; thr_a = a; thr_b = b;
      res_data = x; res_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "done in reset", 32'(done), 32'd0);
      chk("R1", "data in reset", 32'(out_data), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         string rq;
         rq = $sformatf("R%0d", VT[i].req);
         apply(VT[i].en, VT[i].mode, VT[i].a, VT[i].b, VT[i].x);
         if (VT[i].acc) model_q = VT[i].x;
         chk(rq, $sformatf("vec %0d done", i), 32'(done), 32'(VT[i].acc));
         chk(rq, $sformatf("vec %0d data", i), 32'(out_data), 32'(model_q));
         @(negedge clk);
         chk("R10", $sformatf("vec %0d pulse drop", i), 32'(done), 32'd0);
         chk("R9", $sformatf("vec %0d hold", i), 32'(out_data), 32'(model_q));
      end

      // R9: rejected result after an accepted one leaves data untouched
      apply(1'b1, 2'd1, 16'd0, 16'd0, 12'd77);
      chk("R9", "accept 77", 32'(out_data), 32'd77);
      apply(1'b1, 2'd0, 16'd0, 16'd0, 12'd500);
      chk("R9", "reject done", 32'(done), 32'd0);
      chk("R9", "reject keeps data", 32'(out_data), 32'd77);

      // R10: back-to-back accepted results, one pulse per result
      cmp_en = 1'b0; res_data = 12'd11; res_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      chk("R10", "first of pair done", 32'(done), 32'd1);
      chk("R10", "first of pair data", 32'(out_data), 32'd11);
      res_data = 12'd22;
      @(posedge clk); @(negedge clk);
      res_valid = 1'b0;
      chk("R10", "second of pair done", 32'(done), 32'd1);
      chk("R10", "second of pair data", 32'(out_data), 32'd22);
      @(negedge clk);
      chk("R10", "pair pulse ends", 32'(done), 32'd0);
      @(negedge clk);
      chk("R10", "no valid no pulse", 32'(done), 32'd0);

      // R1: asynchronous reset mid-run, checked before any clock edge
      apply(1'b0, 2'd0, 16'd0, 16'd0, 12'd333);
      #2 rst_n = 1'b0;
      #1;
      chk("R1", "async clear done", 32'(done), 32'd0);
      chk("R1", "async clear data", 32'(out_data), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule